// File: doc/BRIEF.md
# Output Divider Range Scanner

This block searches for output divider settings that bring a fast oscillator (DCO) rate into a requested output-rate window. After a start strobe it captures the DCO rate, the window bounds and the largest divider the hardware supports. It then derives the usable divider range from these values.

It steps through the range from the smallest divider to the largest. For each divider it presents the divider and the resulting integer output rate to a consumer, one candidate at a time. The consumer judges each candidate and either takes it or lets it pass. The search ends on the first candidate taken, or when the range runs out.

A single shared iterative divider does all the arithmetic. It finds both range limits first and then each candidate rate, so every step costs a fixed number of cycles set by the data width.

Top module: `div_scan`

## Requirements
- R1: When the requested minimum output rate is zero, the scan treats it as 1, so the largest divider is bounded only by the DCO rate and the hardware maximum.
- R2: When the requested maximum output rate is zero, the scan treats it as the largest unsigned value of the rate width, so the first divider offered is 1.
- R3: The first divider offered is the larger of 1 and the DCO rate divided by the maximum output rate, rounded up.
- R4: The last divider offered is the smaller of the DCO rate divided by the minimum output rate (rounded down) and the hardware divider maximum.
- R5: Candidates appear in increasing divider order, each for exactly one cycle with `cand_valid` high. Each carries `cand_rate` equal to the DCO rate divided by `cand_div`, rounded down, and every rate lies inside the effective window.
- R6: If `accept` is high in a cycle where `cand_valid` is high, the scan stops on the next clock edge. `done` and `found` go high, and `sel_div`/`sel_rate` hold that candidate until the next start.
- R7: If no candidate is taken, `done` rises with `found` low after the last divider. This includes an empty range (first divider above last, or a divider maximum of zero), in which case no candidate is offered at all.
- R8: After reset, `busy`, `cand_valid`, `done` and `found` are low. `done` stays low from an accepted start until the scan finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; taken only while not busy |
| dco_rate | input | W | DCO rate |
| out_min | input | W | Lowest acceptable output rate (0 means 1) |
| out_max | input | W | Highest acceptable output rate (0 means no limit) |
| div_max | input | DW | Largest divider the hardware supports |
| accept | input | 1 | Consumer takes the candidate shown this cycle |
| busy | output | 1 | Scan in progress |
| cand_valid | output | 1 | A candidate is presented this cycle |
| cand_div | output | DW | Candidate divider |
| cand_rate | output | W | Candidate output rate |
| done | output | 1 | Scan finished; held until next start |
| found | output | 1 | A candidate was taken |
| sel_div | output | DW | Divider that was taken |
| sel_rate | output | W | Output rate that was taken |

## Verification
The bench instantiates the block with W = 16 and DW = 5. With these values each divide step takes 16 cycles, and a full range of 31 dividers fits within a few hundred cycles. This width also lets the bench reach the extremes directly: a DCO rate near the top of the 16-bit range with unbounded window limits, a divider maximum of 0, and a window that is narrower than one divider step. Because the expected rates fit in a plain integer, the bench compares every offered candidate against its own list and can take the first, a middle, the last or no candidate.

// File: rtl/div_scan.sv
module div_scan #(
  parameter int W  = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dco_rate,
  input  logic [W-1:0]  out_min,
  input  logic [W-1:0]  out_max,
  input  logic [DW-1:0] div_max,
  input  logic          accept,
  output logic          busy,
  output logic          cand_valid,
  output logic [DW-1:0] cand_div,
  output logic [W-1:0]  cand_rate,
  output logic          done,
  output logic          found,
  output logic [DW-1:0] sel_div,
  output logic [W-1:0]  sel_rate
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_DIV, S_OFFER} st_t;

  st_t            st;
  logic [W-1:0]   dco_q, omin_q, omax_q, first_q;
  logic [DW-1:0]  dmax_q, last_q, cur;
  logic [W-1:0]   quo, rem, den;
  logic [CW-1:0]  cnt;
  logic           done_q, found_q;
  logic [DW-1:0]  sel_div_q;
  logic [W-1:0]   sel_rate_q;

  logic [W:0]     rem_sh;
  logic           ge;
  logic           div_rdy;
  logic [W-1:0]   ceil_q, first_nx, dmax_w;
  logic [DW-1:0]  last_nx;

  assign rem_sh   = {rem, quo[W-1]};
  assign ge       = rem_sh >= {1'b0, den};
  assign div_rdy  = (cnt == '0);
  assign ceil_q   = quo + W'(rem != '0);
  assign first_nx = (ceil_q == '0) ? W'(1) : ceil_q;
  assign dmax_w   = W'(dmax_q);
  assign last_nx  = (quo < dmax_w) ? quo[DW-1:0] : dmax_q;

  assign busy       = (st != S_IDLE);
  assign cand_valid = (st == S_OFFER);
  assign cand_div   = cur;
  assign cand_rate  = quo;
  assign done       = done_q;
  assign found      = found_q;
  assign sel_div    = sel_div_q;
  assign sel_rate   = sel_rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dco_q <= '0; omin_q <= '0; omax_q <= '0; first_q <= '0;
      dmax_q <= '0; last_q <= '0; cur <= '0;
      quo <= '0; rem <= '0; den <= '0; cnt <= '0;
      done_q <= 1'b0; found_q <= 1'b0;
      sel_div_q <= '0; sel_rate_q <= '0;
    end else begin
      if (st != S_IDLE && st != S_OFFER && !div_rdy) begin
        quo <= {quo[W-2:0], ge};
        rem <= ge ? W'(rem_sh - {1'b0, den}) : rem_sh[W-1:0];
        cnt <= cnt - 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          dco_q   <= dco_rate;
          omin_q  <= (out_min == '0) ? W'(1) : out_min;
          omax_q  <= (out_max == '0) ? '1 : out_max;
          dmax_q  <= div_max;
          done_q  <= 1'b0;
          found_q <= 1'b0;
          quo <= dco_rate; rem <= '0; cnt <= CW'(W);
          den <= (out_max == '0) ? '1 : out_max;
          st  <= S_LO;
        end
        S_LO: if (div_rdy) begin
          first_q <= first_nx;
          quo <= dco_q; rem <= '0; cnt <= CW'(W); den <= omin_q;
          st  <= S_HI;
        end
        S_HI: if (div_rdy) begin
          last_q <= last_nx;
          if (first_q > W'(last_nx)) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cur <= first_q[DW-1:0];
            quo <= dco_q; rem <= '0; cnt <= CW'(W); den <= first_q;
            st  <= S_DIV;
          end
        end
        S_DIV: if (div_rdy) st <= S_OFFER;
        S_OFFER: begin
          if (accept) begin
            done_q     <= 1'b1;
            found_q    <= 1'b1;
            sel_div_q  <= cur;
            sel_rate_q <= quo;
            st         <= S_IDLE;
          end else if (cur == last_q) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cur <= cur + 1'b1;
            quo <= dco_q; rem <= '0; cnt <= CW'(W); den <= W'(cur + 1'b1);
            st  <= S_DIV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rate_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_rate >= omin_q && cand_rate <= omax_q));
  p_div_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_div != '0 && cand_div <= dmax_q));
  p_single_cycle_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |=> !cand_valid);
  p_stop_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && accept) |=> (done && found && sel_div == $past(cand_div)
                                && sel_rate == $past(cand_rate)));
  p_no_offer_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cand_valid && !busy));
  p_start_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);
endmodule

// File: tb/test_div_scan.sv
module test_div_scan;
  localparam int W  = 16;
  localparam int DW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  dco_rate = '0, out_min = '0, out_max = '0;
  logic [DW-1:0] div_max = '0;
  logic          accept = 1'b0;
  logic          busy, cand_valid, done, found;
  logic [DW-1:0] cand_div, sel_div;
  logic [W-1:0]  cand_rate, sel_rate;

  int applied = 0;
  int errors  = 0;
  int take_div = -1;
  int q_div[$];
  int q_rate[$];

  always #5 clk = ~clk;

  div_scan #(.W(W), .DW(DW)) i_div_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .dco_rate(dco_rate),
    .out_min(out_min), .out_max(out_max), .div_max(div_max),
    .accept(accept), .busy(busy), .cand_valid(cand_valid),
    .cand_div(cand_div), .cand_rate(cand_rate), .done(done),
    .found(found), .sel_div(sel_div), .sel_rate(sel_rate));

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected candidates, answers with accept
  always @(negedge clk) begin
    if (cand_valid) begin
      if (q_div.size() == 0) begin
        check("R7 unexpected candidate", int'(cand_div), -1);
        accept = 1'b0;
      end else begin
        int ed, er;
        ed = q_div.pop_front();
        er = q_rate.pop_front();
        check("R5 candidate divider order", int'(cand_div), ed);
        check("R5 candidate rate", int'(cand_rate), er);
        accept = (int'(cand_div) == take_div);
      end
    end else begin
      accept = 1'b0;
    end
  end

  task automatic run(input int dco, input int omin, input int omax,
                     input int dmax, input int take, input string req);
    int emin, emax, first, last, exp_found, exp_rate, wd;
    emin  = (omin == 0) ? 1 : omin;
    emax  = (omax == 0) ? 65535 : omax;
    first = (dco + emax - 1) / emax;
    if (first < 1) first = 1;
    last  = dco / emin;
    if (last > dmax) last = dmax;
    exp_found = 0; exp_rate = 0;
    q_div.delete(); q_rate.delete();
    for (int d = first; d <= last; d++) begin
      q_div.push_back(d);
      q_rate.push_back(dco / d);
      if (d == take) begin
        exp_found = 1; exp_rate = dco / d;
        break;
      end
    end
    take_div = take;
    @(negedge clk);
    dco_rate = W'(dco); out_min = W'(omin); out_max = W'(omax);
    div_max = DW'(dmax); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R8 done low while scanning"}, int'(done), 0);
    wd = 0;
    while (!done && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 5000) begin
      errors++;
      $display("FAIL %s: watchdog, actual no done expected done", req);
    end
    check({req, " all expected candidates offered"}, q_div.size(), 0);
    check({req, " found"}, int'(found), exp_found);
    if (exp_found == 1) begin
      check({req, " R6 sel_div"}, int'(sel_div), take);
      check({req, " R6 sel_rate"}, int'(sel_rate), exp_rate);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset cand_valid", int'(cand_valid), 0);
    check("R8 reset done", int'(done), 0);
    check("R8 reset found", int'(found), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1000, 100, 300, 31, -1, "R3 R4 R7 window 4..10 none taken");
    run(1000, 100, 300, 31, 6,  "R6 take middle");
    run(1000, 100, 300, 31, 4,  "R6 take first");
    run(1000, 100, 300, 31, 10, "R6 take last");
    run(20, 0, 0, 31, -1,       "R1 R2 zero bounds 1..20");
    run(60000, 1, 0, 31, 31,    "R4 hardware max limits");
    run(60000, 2000, 0, 31, -1, "R2 R4 dco bound 1..30");
    run(1000, 600, 700, 31, -1, "R7 empty narrow window");
    run(1000, 0, 0, 0, -1,      "R7 divider max zero");
    run(50, 0, 1, 31, -1,       "R3 first above max");
    run(65535, 0, 5000, 20, 14, "R3 ceil first 14");
    check("R8 idle after runs", int'(busy), 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule